// File: doc/BRIEF.md
# MESI Line-State Tracker

This block keeps the coherence state of every line in a write-back data cache. Each line holds one of four 2-bit codes (Invalid, Shared, Exclusive, Modified). The cache controller presents one event per cycle: a local read, a local write, a fill from memory, or an invalidate. The block then answers whether the line was present, whether a write had to be refused, and, when a dirty line is dropped, that it must first be copied back to memory. The tag and data arrays sit outside this block. So does any snooping logic beyond the single invalidate event.

A separate query port reads the state of any line at any time, together with a flag that says whether a local write is allowed. When a Modified line is invalidated, the block raises a write-back request for one cycle and names the line. The line stays Modified during that cycle, so the controller can still locate its data, and becomes Invalid one cycle later. While that request is up, the block accepts no event.

Top module: `mesi_state_tracker`

## Requirements
- R1: After a synchronous active-low reset, every line reads Invalid, `wb_req` is low and `ev_ready` is high.
- R2: State codes are Invalid = 2'b00, Shared = 2'b01, Exclusive = 2'b10, Modified = 2'b11. `q_state` shows the stored code of line `q_index`, and `q_writable` is high only for Exclusive and Modified.
- R3: A read event (`ev_kind` = 2'b00) reports `rsp_hit` high exactly when the line is not Invalid, and never changes the state.
- R4: A fill event (`ev_kind` = 2'b10) on an Invalid line makes it Shared when `ev_fill_excl` is 0 and Exclusive when it is 1. A fill on a line that is not Invalid is ignored.
- R5: A write event (`ev_kind` = 2'b01) on an Exclusive line makes it Modified. On a Modified line it leaves the line Modified. On an Invalid line it reports a miss and changes nothing.
- R6: A write event on a Shared line raises `rsp_wr_denied` and leaves the line Shared.
- R7: An invalidate event (`ev_kind` = 2'b11) on a Modified line raises `wb_req` with `wb_index` set to that line, for exactly the one cycle after acceptance. The line reads Modified during that cycle and Invalid afterwards.
- R8: While `wb_req` is high, `ev_ready` is low, and any event presented in that cycle is ignored (no response, no state change).
- R9: An invalidate event on an Invalid, Shared or Exclusive line makes it Invalid in the next cycle and does not raise `wb_req`.
- R10: An event is accepted on a rising edge with `ev_valid` and `ev_ready` both high. In the following cycle `rsp_valid` is high, and `rsp_prev` carries the state the line held before the event.
- R11: An event changes only the line it names.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ev_valid | input | 1 | Event present |
| ev_ready | output | 1 | Block can accept an event |
| ev_kind | input | 2 | 00 read, 01 write, 10 fill, 11 invalidate |
| ev_index | input | IDX_W | Line addressed by the event |
| ev_fill_excl | input | 1 | Fill grants exclusive ownership |
| rsp_valid | output | 1 | One-cycle pulse after an accepted event |
| rsp_hit | output | 1 | Line was valid when the event arrived |
| rsp_wr_denied | output | 1 | Write refused on a Shared line |
| rsp_prev | output | 2 | State of the line before the event |
| wb_req | output | 1 | Dirty line must be written back |
| wb_index | output | IDX_W | Line to write back |
| q_index | input | IDX_W | Line to inspect |
| q_state | output | 2 | State code of line `q_index` |
| q_writable | output | 1 | Line `q_index` may be written locally |

## Verification
Some rules hold on every cycle, and the embedded assertions check them there: the write-back pulse follows an invalidate of a Modified line and lasts one cycle, no response appears while that pulse is up, a refused write always comes with a hit, an Invalid line never reports a hit, and reset leaves the read ports showing Invalid. Other behaviour only shows up over an event sequence, and only the bench's scenarios can demonstrate it. That includes the full transition walk across lines (fills with and without exclusivity, fills ignored on valid lines, Exclusive-to-Modified upgrades), keeping neighbouring lines untouched, the line staying Modified during the write-back cycle, and dropping an event offered while the block is busy.

// File: rtl/mesi_pkg.sv
// Shared types for the line-state tracker.
// Assumes a 2-bit state per line and a 2-bit event code from the controller.
package mesi_pkg;

    typedef enum logic [1:0] {
        LS_INV = 2'b00,
        LS_SHR = 2'b01,
        LS_EXC = 2'b10,
        LS_MOD = 2'b11
    } line_state_t;

    typedef enum logic [1:0] {
        EV_READ  = 2'b00,
        EV_WRITE = 2'b01,
        EV_FILL  = 2'b10,
        EV_DROP  = 2'b11
    } ev_kind_t;

    // Outcome of one event applied to one line's current state.
    typedef struct packed {
        logic        upd;    // write nxt into the table now
        line_state_t nxt;    // state to store
        logic        hit;    // line was valid
        logic        deny;   // local write refused
        logic        defer;  // dirty drop: write back first, clear one cycle later
    } step_t;

    function automatic logic state_writable(line_state_t s);
        return (s == LS_EXC) || (s == LS_MOD);
    endfunction

endpackage

// File: rtl/mesi_line_table.sv
// Per-line state storage: one 2-bit register per cache line, one write port,
// two combinational read ports. Assumes LINES is a power of two so that every
// index value names a line. Reset clears every line to Invalid.
module mesi_line_table
    import mesi_pkg::*;
#(
    parameter int LINES = 64,
    localparam int IDX_W = $clog2(LINES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  line_state_t      wr_state,
    input  logic [IDX_W-1:0] ra_idx,
    output line_state_t      ra_state,
    input  logic [IDX_W-1:0] rb_idx,
    output line_state_t      rb_state
);

    line_state_t cells [LINES];

    for (genvar g = 0; g < LINES; g++) begin : g_line
        line_state_t cell_q;

        // Hold one line's state; load it when the write port names this line.
        always_ff @(posedge clk) begin
            if (!rst_n)
                cell_q <= LS_INV;
            else if (wr_en && (wr_idx == IDX_W'(g)))
                cell_q <= wr_state;
        end

        assign cells[g] = cell_q;
    end

    assign ra_state = cells[ra_idx];
    assign rb_state = cells[rb_idx];

    AST_RESET_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (ra_state == LS_INV && rb_state == LS_INV)); // R1

endmodule

// File: rtl/mesi_step.sv
// Transition decision for one line: given its current state and an event,
// says whether and how the table is updated and what is reported.
// Purely combinational; assumes the caller applies the result only when the
// event is accepted.
module mesi_step
    import mesi_pkg::*;
(
    input  line_state_t cur,
    input  ev_kind_t    kind,
    input  logic        fill_excl,
    output step_t       res
);

    // Decide the next state and response flags for the presented event.
    always_comb begin
        res.upd   = 1'b0;
        res.nxt   = cur;
        res.hit   = (cur != LS_INV);
        res.deny  = 1'b0;
        res.defer = 1'b0;
        unique case (kind)
            EV_READ: begin
            end
            EV_WRITE: begin
                if (cur == LS_SHR) begin
                    res.deny = 1'b1;
                end else if (cur == LS_EXC) begin
                    res.upd = 1'b1;
                    res.nxt = LS_MOD;
                end
            end
            EV_FILL: begin
                if (cur == LS_INV) begin
                    res.upd = 1'b1;
                    res.nxt = fill_excl ? LS_EXC : LS_SHR;
                end
            end
            EV_DROP: begin
                if (cur == LS_MOD) begin
                    res.defer = 1'b1;
                end else if (cur != LS_INV) begin
                    res.upd = 1'b1;
                    res.nxt = LS_INV;
                end
            end
            default: begin
            end
        endcase
    end

endmodule

// File: rtl/mesi_state_tracker.sv
// Coherence state tracker for a write-back data cache.
// Accepts one event per cycle (read, write, fill, invalidate) for a line,
// updates that line's 2-bit state, and returns a registered response one cycle
// later. Invalidating a Modified line raises a one-cycle write-back request;
// the line is cleared at the end of that cycle, and no event is accepted
// during it. Assumes the controller holds an event until ev_ready is high.
module mesi_state_tracker
    import mesi_pkg::*;
#(
    parameter int LINES = 64,
    localparam int IDX_W = $clog2(LINES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ev_valid,
    output logic             ev_ready,
    input  logic [1:0]       ev_kind,
    input  logic [IDX_W-1:0] ev_index,
    input  logic             ev_fill_excl,
    output logic             rsp_valid,
    output logic             rsp_hit,
    output logic             rsp_wr_denied,
    output logic [1:0]       rsp_prev,
    output logic             wb_req,
    output logic [IDX_W-1:0] wb_index,
    input  logic [IDX_W-1:0] q_index,
    output logic [1:0]       q_state,
    output logic             q_writable
);

    ev_kind_t         kind_in;
    line_state_t      cur_state;
    line_state_t      look_state;
    step_t            step;
    logic             accept;
    logic             pend_q;
    logic [IDX_W-1:0] pend_idx_q;
    logic             tbl_wr_en;
    logic [IDX_W-1:0] tbl_wr_idx;
    line_state_t      tbl_wr_state;

    assign kind_in  = ev_kind_t'(ev_kind);
    assign ev_ready = !pend_q;
    assign accept   = ev_valid && ev_ready;

    mesi_line_table #(.LINES(LINES)) u_table (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (tbl_wr_en),
        .wr_idx   (tbl_wr_idx),
        .wr_state (tbl_wr_state),
        .ra_idx   (ev_index),
        .ra_state (cur_state),
        .rb_idx   (q_index),
        .rb_state (look_state)
    );

    mesi_step u_step (
        .cur       (cur_state),
        .kind      (kind_in),
        .fill_excl (ev_fill_excl),
        .res       (step)
    );

    // Pick the table write: a pending dirty drop clears its line first.
    always_comb begin
        if (pend_q) begin
            tbl_wr_en    = 1'b1;
            tbl_wr_idx   = pend_idx_q;
            tbl_wr_state = LS_INV;
        end else begin
            tbl_wr_en    = accept && step.upd;
            tbl_wr_idx   = ev_index;
            tbl_wr_state = step.nxt;
        end
    end

    // Track a dirty drop that waits one cycle for its write-back.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q     <= 1'b0;
            pend_idx_q <= '0;
        end else begin
            pend_q <= accept && step.defer;
            if (accept)
                pend_idx_q <= ev_index;
        end
    end

    // Register the response to the accepted event.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid     <= 1'b0;
            rsp_hit       <= 1'b0;
            rsp_wr_denied <= 1'b0;
            rsp_prev      <= LS_INV;
        end else begin
            rsp_valid <= accept;
            if (accept) begin
                rsp_hit       <= step.hit;
                rsp_wr_denied <= step.deny;
                rsp_prev      <= cur_state;
            end
        end
    end

    assign wb_req     = pend_q;
    assign wb_index   = pend_idx_q;
    assign q_state    = look_state;
    assign q_writable = state_writable(look_state);

    AST_WB_AFTER_DIRTY_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && kind_in == EV_DROP && cur_state == LS_MOD)
        |=> (wb_req && wb_index == $past(ev_index))); // R7
    AST_WB_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        wb_req |=> !wb_req); // R7
    AST_NO_RSP_WHILE_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
        wb_req |=> !rsp_valid); // R8
    AST_DENY_ON_SHARED: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && kind_in == EV_WRITE && cur_state == LS_SHR) |=> rsp_wr_denied); // R6
    AST_DENY_NEEDS_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_wr_denied) |-> rsp_hit); // R6
    AST_INVALID_NO_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_prev == LS_INV) |-> (!rsp_hit && !rsp_wr_denied)); // R3

endmodule

// File: tb/mesi_state_tracker_bench.sv
module mesi_state_tracker_bench;

    localparam int LINES = 64;
    localparam int IW    = 6;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ev_valid = 1'b0;
    logic          ev_ready;
    logic [1:0]    ev_kind = 2'b00;
    logic [IW-1:0] ev_index = '0;
    logic          ev_fill_excl = 1'b0;
    logic          rsp_valid, rsp_hit, rsp_wr_denied;
    logic [1:0]    rsp_prev;
    logic          wb_req;
    logic [IW-1:0] wb_index;
    logic [IW-1:0] q_index = '0;
    logic [1:0]    q_state;
    logic          q_writable;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    mesi_state_tracker #(.LINES(LINES)) u_mesi_state_tracker (
        .clk(clk), .rst_n(rst_n), .ev_valid(ev_valid), .ev_ready(ev_ready),
        .ev_kind(ev_kind), .ev_index(ev_index), .ev_fill_excl(ev_fill_excl),
        .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_wr_denied(rsp_wr_denied),
        .rsp_prev(rsp_prev), .wb_req(wb_req), .wb_index(wb_index),
        .q_index(q_index), .q_state(q_state), .q_writable(q_writable)
    );

    // Vector: {req[19:16], kind[15:14], idx[13:8], excl[7], hit[6], deny[5], wb[4], prev[3:2], after[1:0]}
    // kinds: 0 read, 1 write, 2 fill, 3 invalidate; states: 0 I, 1 S, 2 E, 3 M
    localparam int NV = 16;
    localparam logic [19:0] VEC [NV] = '{
        {4'd3,  2'd0, 6'd3,  1'b0, 1'b0, 1'b0, 1'b0, 2'd0, 2'd0}, // R3 read miss
        {4'd5,  2'd1, 6'd3,  1'b0, 1'b0, 1'b0, 1'b0, 2'd0, 2'd0}, // R5 write miss
        {4'd4,  2'd2, 6'd3,  1'b0, 1'b0, 1'b0, 1'b0, 2'd0, 2'd1}, // R4 fill shared
        {4'd3,  2'd0, 6'd3,  1'b0, 1'b1, 1'b0, 1'b0, 2'd1, 2'd1}, // R3 read hit
        {4'd6,  2'd1, 6'd3,  1'b0, 1'b1, 1'b1, 1'b0, 2'd1, 2'd1}, // R6 write denied
        {4'd4,  2'd2, 6'd3,  1'b1, 1'b1, 1'b0, 1'b0, 2'd1, 2'd1}, // R4 fill ignored
        {4'd9,  2'd3, 6'd3,  1'b0, 1'b1, 1'b0, 1'b0, 2'd1, 2'd0}, // R9 drop shared
        {4'd4,  2'd2, 6'd5,  1'b1, 1'b0, 1'b0, 1'b0, 2'd0, 2'd2}, // R4 fill exclusive
        {4'd5,  2'd1, 6'd5,  1'b0, 1'b1, 1'b0, 1'b0, 2'd2, 2'd3}, // R5 E to M
        {4'd5,  2'd1, 6'd5,  1'b0, 1'b1, 1'b0, 1'b0, 2'd3, 2'd3}, // R5 M stays
        {4'd11, 2'd0, 6'd3,  1'b0, 1'b0, 1'b0, 1'b0, 2'd0, 2'd0}, // R11 neighbour untouched
        {4'd7,  2'd3, 6'd5,  1'b0, 1'b1, 1'b0, 1'b1, 2'd3, 2'd0}, // R7 dirty drop
        {4'd4,  2'd2, 6'd63, 1'b0, 1'b0, 1'b0, 1'b0, 2'd0, 2'd1}, // R4 top line
        {4'd9,  2'd3, 6'd63, 1'b0, 1'b1, 1'b0, 1'b0, 2'd1, 2'd0}, // R9
        {4'd4,  2'd2, 6'd63, 1'b1, 1'b0, 1'b0, 1'b0, 2'd0, 2'd2}, // R4
        {4'd9,  2'd3, 6'd63, 1'b0, 1'b1, 1'b0, 1'b0, 2'd2, 2'd0}  // R9 drop exclusive
    };

    task automatic check(input string req, input int act, input int exp, input string what);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Present one event for one accepting edge; returns at the next falling edge.
    task automatic send(input logic [1:0] k, input logic [IW-1:0] idx, input logic ex);
        @(negedge clk);
        ev_valid = 1'b1; ev_kind = k; ev_index = idx; ev_fill_excl = ex;
        @(negedge clk);
        ev_valid = 1'b0;
    endtask

    task automatic peek(input logic [IW-1:0] idx);
        q_index = idx;
        #1;
    endtask

    task automatic run_vec(input logic [19:0] v);
        string tag;
        tag = $sformatf("R%0d", v[19:16]);
        send(v[15:14], v[13:8], v[7]);
        peek(v[13:8]);
        check(tag, int'(rsp_valid), 1, "rsp_valid");                       // R10
        check(tag, int'(rsp_hit), int'(v[6]), "rsp_hit");
        check(tag, int'(rsp_wr_denied), int'(v[5]), "rsp_wr_denied");
        check(tag, int'(rsp_prev), int'(v[3:2]), "rsp_prev");
        check(tag, int'(wb_req), int'(v[4]), "wb_req");
        if (v[4]) begin
            check(tag, int'(wb_index), int'(v[13:8]), "wb_index");
            check(tag, int'(q_state), 3, "state during write-back");
            check(tag, int'(ev_ready), 0, "ev_ready during write-back");
            @(negedge clk);
            peek(v[13:8]);
            check(tag, int'(wb_req), 0, "wb_req after one cycle");
        end
        check(tag, int'(q_state), int'(v[1:0]), "state after event");
    endtask

    task automatic check_all_invalid(input string what);
        int bad = 0;
        for (int i = 0; i < LINES; i++) begin
            peek(IW'(i));
            if (q_state !== 2'b00) bad++;
        end
        check("R1", bad, 0, what);
        check("R1", int'(wb_req), 0, "wb_req after reset");
        check("R1", int'(ev_ready), 1, "ev_ready after reset");
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check_all_invalid("lines not Invalid after reset");            // R1

        for (int n = 0; n < NV; n++) run_vec(VEC[n]);

        // R2: writable flag and code values at the query port
        send(2'd2, 6'd9, 1'b1);
        peek(6'd9);
        check("R2", int'(q_state), 2, "Exclusive code");
        check("R2", int'(q_writable), 1, "Exclusive writable");
        send(2'd1, 6'd9, 1'b0);
        peek(6'd9);
        check("R2", int'(q_state), 3, "Modified code");
        check("R2", int'(q_writable), 1, "Modified writable");
        send(2'd2, 6'd10, 1'b0);
        peek(6'd10);
        check("R2", int'(q_state), 1, "Shared code");
        check("R2", int'(q_writable), 0, "Shared not writable");
        peek(6'd11);
        check("R2", int'(q_writable), 0, "Invalid not writable");

        // R8: an event offered during the write-back cycle is dropped
        send(2'd2, 6'd7, 1'b1);
        send(2'd1, 6'd7, 1'b0);
        @(negedge clk);
        ev_valid = 1'b1; ev_kind = 2'd3; ev_index = 6'd7; ev_fill_excl = 1'b0;
        @(negedge clk);
        ev_kind = 2'd2; ev_index = 6'd8; ev_fill_excl = 1'b1;
        #1;
        check("R8", int'(ev_ready), 0, "ev_ready during write-back");
        @(negedge clk);
        ev_valid = 1'b0;
        check("R8", int'(rsp_valid), 0, "response to ignored event");
        peek(6'd8);
        check("R8", int'(q_state), 0, "ignored fill changed line");
        peek(6'd7);
        check("R7", int'(q_state), 0, "dirty line cleared");

        // R1: reset in mid-run clears populated lines
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check_all_invalid("lines not Invalid after second reset");

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule